// File: doc/BRIEF.md
# Low-Power DDR SDRAM Power-Up Command Sequencer

This block sits on the controller side of a low-power double-data-rate SDRAM and steps through the start-up routine that the memory requires before it can take ordinary traffic. CKE is high from reset onward. The block waits for the clock-stable flag. It then holds no-operation on the command bus for a programmed settling interval. After that it issues one precharge-all command, waits the row-precharge interval, and issues two auto-refresh commands. Each auto-refresh is followed by a full refresh-recovery interval of no-operation cycles. At that point it raises `init_done`.

All three intervals are parameters counted in clock cycles. A reset at any point, which stands in for a supply interruption, discards all progress. The routine then runs again from the beginning, and `init_done` stays low until it completes. After completion the command bus rests at no-operation so that the traffic path can take it over. The low-power request input can pull CKE low only once `init_done` is high.

Top module: `lpddr_init_seq`

## Requirements
- R1: While `rst_n` is low, and after reset until `clk_stable` is sampled high, `cke` is 1, `init_done` is 0, `ba` is 0 and the bus carries NOP (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1, `a10`=0).
- R2: Take cycle 0 as the first cycle after the clock edge at which `clk_stable` is sampled high. The bus carries NOP for exactly `T_STAB_CYC` cycles, which are cycles 0 to `T_STAB_CYC`-1.
- R3: The first non-NOP command is precharge-all (`cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, `a10`=1). It is driven for exactly one cycle, at cycle `T_STAB_CYC`.
- R4: NOP follows the precharge-all for exactly `T_RP_CYC` cycles.
- R5: The first auto-refresh (`cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1, `a10`=0) is driven for one cycle. NOP then follows for exactly `T_RFC_CYC` cycles.
- R6: A second auto-refresh is then driven for one cycle, followed by exactly `T_RFC_CYC` NOP cycles. The sequence contains exactly two refreshes and no command other than NOP, precharge-all and auto-refresh.
- R7: `init_done` is a registered output. It rises in the cycle after the last refresh-recovery cycle, at cycle `T_STAB_CYC`+`T_RP_CYC`+2·`T_RFC_CYC`+3. It then stays high with the bus at NOP until reset.
- R8: A reset asserted at any cycle, including after completion, restarts the whole sequence. `init_done` reads 0 from the reset until the rerun completes.
- R9: Before `init_done` is high, `pd_req` is ignored and `cke` stays 1. After that, `cke` is registered as the inverse of `pd_req` as sampled while `init_done` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the sequence |
| clk_stable | input | 1 | High once the memory clock is stable |
| pd_req | input | 1 | Request to drop CKE for power-down or clock stop |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10; selects all banks on precharge |
| ba | output | 2 | Bank address, held at zero |
| init_done | output | 1 | Sequence complete |

## Verification
The hardest case to reach from the ports is a supply interruption that lands on a particular cycle of the sequence. Examples are the single cycle of a refresh command, the last cycle of a countdown, or the first cycle after `init_done` rises. A restart from such a point must still produce an untouched full-length sequence. The stimulus therefore uses short intervals and sweeps the reset point across every cycle index from the first settling cycle through to beyond completion. After each aborted run, the next run is checked cycle by cycle against an arithmetically computed timeline. `pd_req` toggles in a fixed pattern throughout, so CKE gating is also exercised on both sides of completion.

// File: rtl/lpinit_pkg.sv
package lpinit_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PREA = 2'd1,
    CMD_REF  = 2'd2
  } init_cmd_e;

  typedef enum logic [3:0] {
    ST_WAIT_CLK = 4'd0,
    ST_STAB     = 4'd1,
    ST_PREA     = 4'd2,
    ST_TRP      = 4'd3,
    ST_REF1     = 4'd4,
    ST_RFC1     = 4'd5,
    ST_REF2     = 4'd6,
    ST_RFC2     = 4'd7,
    ST_DONE     = 4'd8
  } init_state_e;

endpackage

// File: rtl/lpinit_wait_timer.sv
module lpinit_wait_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R2/R4/R5: an unloaded count moves down by exactly one per cycle
  a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R2: a count that has reached zero stays there until reloaded
  a_r2_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/lpinit_cmd_enc.sv
module lpinit_cmd_enc
  import lpinit_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  init_cmd_e        cmd,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             a10,
  output logic [BA_W-1:0]  ba
);

  always_comb begin
    cs_n  = 1'b0;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    a10   = 1'b0;
    ba    = '0;
    unique case (cmd)
      CMD_PREA: begin
        ras_n = 1'b0;
        we_n  = 1'b0;
        a10   = 1'b1;
      end
      CMD_REF: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lpddr_init_seq.sv
module lpddr_init_seq
  import lpinit_pkg::*;
#(
  parameter int T_STAB_CYC = 50000,
  parameter int T_RP_CYC   = 4,
  parameter int T_RFC_CYC  = 20,
  parameter int BA_W       = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_stable,
  input  logic            pd_req,
  output logic            cke,
  output logic            cs_n,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic            a10,
  output logic [BA_W-1:0] ba,
  output logic            init_done
);

  localparam int MAX_A = (T_STAB_CYC > T_RP_CYC) ? T_STAB_CYC : T_RP_CYC;
  localparam int MAX_C = (MAX_A > T_RFC_CYC) ? MAX_A : T_RFC_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  init_state_e   state_q, state_d;
  init_cmd_e     cmd;
  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val;
  logic          done_q, cke_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_CLK: if (clk_stable)  state_d = ST_STAB;
      ST_STAB:     if (tmr_expired) state_d = ST_PREA;
      ST_PREA:                      state_d = ST_TRP;
      ST_TRP:      if (tmr_expired) state_d = ST_REF1;
      ST_REF1:                      state_d = ST_RFC1;
      ST_RFC1:     if (tmr_expired) state_d = ST_REF2;
      ST_REF2:                      state_d = ST_RFC2;
      ST_RFC2:     if (tmr_expired) state_d = ST_DONE;
      default:                      state_d = ST_DONE;
    endcase
  end

  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_STAB:          tmr_val = CW'(T_STAB_CYC - 1);
      ST_TRP:           tmr_val = CW'(T_RP_CYC - 1);
      ST_RFC1, ST_RFC2: tmr_val = CW'(T_RFC_CYC - 1);
      default: begin
        tmr_val  = '0;
        tmr_load = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT_CLK;
      done_q  <= 1'b0;
      cke_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      done_q  <= done_q | (state_q == ST_RFC2 && tmr_expired);
      cke_q   <= !(done_q && pd_req);
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PREA:          cmd = CMD_PREA;
      ST_REF1, ST_REF2: cmd = CMD_REF;
      default:          cmd = CMD_NOP;
    endcase
  end

  lpinit_wait_timer #(.CW(CW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  lpinit_cmd_enc #(.BA_W(BA_W)) enc_i (
    .cmd   (cmd),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .a10   (a10),
    .ba    (ba)
  );

  assign cke       = cke_q;
  assign init_done = done_q;

  // R9: no CKE drop while the sequence is incomplete
  a_r9_cke_held: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |=> cke);

  // R3: a row-strobe command with write enable low must select all banks
  a_r3_prea_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && !we_n) |-> a10);

  // R6: every executable command lasts exactly one cycle
  a_r6_single_cycle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |=> ras_n);

  // R7: completion is sticky until reset
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R7: once complete, the bus rests at NOP
  a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (ras_n && cas_n && we_n));

endmodule

// File: tb/lpddr_init_seq_tb_top.sv
`timescale 1ns/1ps
module lpddr_init_seq_tb_top;

  localparam int S = 12;
  localparam int P = 3;
  localparam int R = 5;
  localparam int E = S + P + 2*R + 3;

  localparam logic [4:0] NOP_V  = 5'b0_111_0;
  localparam logic [4:0] PREA_V = 5'b0_010_1;
  localparam logic [4:0] REF_V  = 5'b0_001_0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_stable = 1'b0;
  logic pd_req = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, a10, init_done;
  logic [1:0] ba;

  int vec = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lpddr_init_seq #(.T_STAB_CYC(S), .T_RP_CYC(P), .T_RFC_CYC(R), .BA_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable), .pd_req(pd_req),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .a10(a10), .ba(ba), .init_done(init_done)
  );

  // vector layout {cke, init_done, ba, cs_n, ras_n, cas_n, we_n, a10}
  task automatic check(input string tag, input logic [8:0] exp);
    logic [8:0] act;
    act = {cke, init_done, ba, cs_n, ras_n, cas_n, we_n, a10};
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_bus(input int t);
    if (t < S)               return NOP_V;   // R2
    if (t == S)              return PREA_V;  // R3
    if (t <= S + P)          return NOP_V;   // R4
    if (t == S + P + 1)      return REF_V;   // R5
    if (t <= S + P + 1 + R)  return NOP_V;   // R5
    if (t == S + P + R + 2)  return REF_V;   // R6
    return NOP_V;                            // R6 / R7
  endfunction

  function automatic string tag_of(input int t);
    if (t < S)                 return "R2";
    if (t == S)                return "R3";
    if (t <= S + P)            return "R4";
    if (t <= S + P + 1 + R)    return "R5";
    if (t < E)                 return "R6";
    if (t == E)                return "R7";
    return "R9";
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int dly, input int abort_at, input bit after_abort);
    bit pd_prev;
    logic exp_cke;
    @(negedge clk);
    rst_n = 1'b0; clk_stable = 1'b0; pd_req = 1'b0;
    #0.5;
    check(after_abort ? "R8" : "R1", {1'b1, 1'b0, 2'b00, NOP_V});
    for (int i = 0; i < 2; i++) begin
      cyc();
      check(after_abort ? "R8" : "R1", {1'b1, 1'b0, 2'b00, NOP_V});
    end
    rst_n = 1'b1;
    for (int i = 0; i < dly; i++) begin
      cyc();
      check("R1", {1'b1, 1'b0, 2'b00, NOP_V});
    end
    clk_stable = 1'b1;
    pd_prev = 1'b0;
    for (int t = 0; t <= E + 4; t++) begin
      cyc();
      exp_cke = !((t - 1 >= E) && pd_prev);
      check(tag_of(t), {exp_cke, (t >= E), 2'b00, exp_bus(t)});
      if (t == abort_at) return;
      pd_prev = ((t % 3) == 1);
      pd_req = pd_prev;
    end
  endtask

  initial begin
    bit prev_abort;
    prev_abort = 1'b0;
    for (int d = 0; d < 4; d++) run(d, -1, 1'b0);
    for (int a = 0; a <= E + 2; a++) begin
      run(1, a, prev_abort);
      prev_abort = 1'b1;
    end
    run(2, -1, 1'b1);  // R8: full rerun after the last abort
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule